// File: doc/BRIEF.md
# Thread Execution Lane

This block is the datapath of one thread inside a SIMD compute core. It holds the thread's register file, an 8-bit arithmetic unit, a three-bit sign flag register and the thread's program counter. A core sequencer decodes each instruction once for every lane and drives the decoded fields into all lanes in parallel. It then pulses a single commit strobe, and every lane updates its registers, flags and program counter on that same clock edge.

Three of the sixteen register indices are read-only views of the thread's identity: its block index, the block size and its index within the block. Kernels read these to work out which data element they own. A compare instruction records whether the first operand is below, equal to or above the second. A later conditional branch tests that record against a three-bit mask carried in the instruction. Fetch, decode and memory traffic stay outside the lane. The register read ports and the arithmetic result are outputs, so a load/store unit or a tracer can use them.

Opcode values on `op_sel`: 0 no-op, 1 conditional branch, 2 compare, 3 add, 4 subtract, 5 multiply, 6 divide, 7 load immediate. Values 8 to 15 behave as no-ops.

Top module: `thread_lane`

## Requirements
- R1: After reset the program counter is 0, the flag register is 000, and registers 0 to 12 read as 0.
- R2: Reading index 13 returns `blk_idx`, index 14 returns `blk_dim` and index 15 returns `thr_idx`, on both read ports, combinationally.
- R3: A committed write whose destination index is 13, 14 or 15 changes nothing; those indices keep returning the identity inputs.
- R4: Opcodes 3 (add), 4 (subtract) and 5 (multiply) produce `rs op rt` modulo 256 on `alu_out`, and on commit write that value to register `rd_idx`.
- R5: Opcode 6 (divide) produces the unsigned quotient `rs / rt` truncated toward zero, and 0 when `rt` is 0.
- R6: Opcode 7 writes `imm_val` into register `rd_idx` on commit.
- R7: Opcode 2 compares `rs` and `rt` as unsigned numbers and on commit sets exactly one flag bit: 100 if rs < rt, 010 if they are equal, 001 if rs > rt (bit 2 negative, bit 1 zero, bit 0 positive).
- R8: On commit, opcode 1 loads `br_target` into the program counter when the bitwise AND of the flag register and `cond_mask` is nonzero. Every other committed instruction advances the counter by one, and 255 wraps to 0.
- R9: While `commit` is low, no register, flag or program counter value changes, whatever the other inputs are.
- R10: Only opcode 2 changes the flag register, and opcodes 0, 1, 2 and 8 to 15 write no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| commit | input | 1 | Update strobe from the core sequencer |
| op_sel | input | 4 | Decoded opcode |
| rd_idx | input | 4 | Destination register index |
| rs_idx | input | 4 | First source register index |
| rt_idx | input | 4 | Second source register index |
| imm_val | input | 8 | Immediate value for load immediate |
| br_target | input | 8 | Branch destination address |
| cond_mask | input | 3 | Branch condition mask (negative, zero, positive) |
| blk_idx | input | 8 | Block index, read at register 13 |
| blk_dim | input | 8 | Threads per block, read at register 14 |
| thr_idx | input | 8 | Thread index in block, read at register 15 |
| rs_val | output | 8 | Value of register `rs_idx` |
| rt_val | output | 8 | Value of register `rt_idx` |
| alu_out | output | 8 | Arithmetic result for the current inputs |
| nzp | output | 3 | Flag register |
| pc | output | 8 | Program counter |

## Verification
A corrupted register shows on `rs_val` as soon as that index is selected, with no clock edge needed. It also feeds into `alu_out` and into the flag set by the next compare. A wrong flag value stays hidden until a branch tests it; then `pc` takes the wrong path on the edge of that commit. An update that slips through without a commit, or a write that lands on a special index, shows up in the next read of that index or as an early `pc` step. The bench therefore reads the state back after every stimulus instead of waiting for a later consumer.

// File: rtl/lane_pkg.sv
package lane_pkg;

  localparam int NZP_W = 3;

  typedef logic [NZP_W-1:0] nzp_t;

  // bit 2 negative, bit 1 zero, bit 0 positive
  localparam nzp_t FLAG_NEG  = 3'b100;
  localparam nzp_t FLAG_ZERO = 3'b010;
  localparam nzp_t FLAG_POS  = 3'b001;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_BR    = 4'd1,
    OP_CMP   = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_MUL   = 4'd5,
    OP_DIV   = 4'd6,
    OP_CONST = 4'd7
  } lane_op_e;

  // true for the opcodes whose commit writes the destination register
  function automatic logic op_writes_reg(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) ||
           (op == OP_DIV) || (op == OP_CONST);
  endfunction

  function automatic logic op_is_cmp(input logic [3:0] op);
    return op == OP_CMP;
  endfunction

  function automatic logic op_is_branch(input logic [3:0] op);
    return op == OP_BR;
  endfunction

endpackage

// File: rtl/lane_regfile.sv
module lane_regfile #(
  parameter int DATA_W   = 8,
  parameter int REG_CNT  = 16,
  parameter int SPEC_CNT = 3,
  localparam int IDX_W   = $clog2(REG_CNT),
  localparam int GEN_CNT = REG_CNT - SPEC_CNT
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [IDX_W-1:0]                rd_a_idx,
  input  logic [IDX_W-1:0]                rd_b_idx,
  input  logic [SPEC_CNT-1:0][DATA_W-1:0] spec_vals,
  output logic [DATA_W-1:0]               rd_a,
  output logic [DATA_W-1:0]               rd_b
);

  logic [DATA_W-1:0] gpr  [GEN_CNT];
  logic [DATA_W-1:0] view [REG_CNT];

  // general registers; indices at or above GEN_CNT have no storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < GEN_CNT; k++) gpr[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < GEN_CNT; k++) begin
        if (wr_idx == IDX_W'(k)) gpr[k] <= wr_data;
      end
    end
  end

  // unified read view: storage below GEN_CNT, identity inputs above
  for (genvar g = 0; g < REG_CNT; g++) begin : g_view
    if (g < GEN_CNT) begin : g_store
      assign view[g] = gpr[g];
    end else begin : g_spec
      assign view[g] = spec_vals[g-GEN_CNT];
    end
  end

  assign rd_a = view[rd_a_idx];
  assign rd_b = view[rd_b_idx];

endmodule

// File: rtl/lane_alu.sv
module lane_alu #(
  parameter int DATA_W = 8
) (
  input  logic [3:0]          op,
  input  logic [DATA_W-1:0]   opa,
  input  logic [DATA_W-1:0]   opb,
  output logic [DATA_W-1:0]   result,
  output lane_pkg::nzp_t      cmp_flags
);
  import lane_pkg::*;

  function automatic logic [DATA_W-1:0] alu_calc(input logic [3:0] f,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] prod;
    logic [DATA_W-1:0]   r;
    prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    case (f)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = prod[DATA_W-1:0];
      OP_DIV:  r = (b == '0) ? '0 : a / b;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic nzp_t cmp_calc(input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b);
    if (a < b)       return FLAG_NEG;
    else if (a == b) return FLAG_ZERO;
    else             return FLAG_POS;
  endfunction

  assign result    = alu_calc(op, opa, opb);
  assign cmp_flags = cmp_calc(opa, opb);

endmodule

// File: rtl/lane_flow.sv
module lane_flow #(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [3:0]         op,
  input  lane_pkg::nzp_t     cmp_flags,
  input  lane_pkg::nzp_t     cond_mask,
  input  logic [ADDR_W-1:0]  target,
  output lane_pkg::nzp_t     nzp_q,
  output logic [ADDR_W-1:0]  pc_q,
  output logic               br_taken
);
  import lane_pkg::*;

  logic [ADDR_W-1:0] pc_next;

  assign br_taken = op_is_branch(op) && ((nzp_q & cond_mask) != '0);
  assign pc_next  = br_taken ? target : pc_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzp_q <= '0;
      pc_q  <= '0;
    end else if (commit) begin
      pc_q <= pc_next;
      if (op_is_cmp(op)) nzp_q <= cmp_flags;
    end
  end

endmodule

// File: rtl/thread_lane.sv
module thread_lane #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int REG_CNT  = 16,
  parameter int SPEC_CNT = 3,
  localparam int IDX_W   = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [3:0]        op_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rs_idx,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic [DATA_W-1:0] imm_val,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [2:0]        cond_mask,
  input  logic [DATA_W-1:0] blk_idx,
  input  logic [DATA_W-1:0] blk_dim,
  input  logic [DATA_W-1:0] thr_idx,
  output logic [DATA_W-1:0] rs_val,
  output logic [DATA_W-1:0] rt_val,
  output logic [DATA_W-1:0] alu_out,
  output logic [2:0]        nzp,
  output logic [ADDR_W-1:0] pc
);
  import lane_pkg::*;

  // named internal events, brought out for the checker
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              br_taken;
  nzp_t              cmp_flags;
  nzp_t              nzp_q;

  logic [SPEC_CNT-1:0][DATA_W-1:0] spec_vals;
  assign spec_vals = {thr_idx, blk_dim, blk_idx};

  assign wr_en   = commit && op_writes_reg(op_sel);
  assign wr_data = (op_sel == OP_CONST) ? imm_val : alu_out;

  lane_regfile #(
    .DATA_W   (DATA_W),
    .REG_CNT  (REG_CNT),
    .SPEC_CNT (SPEC_CNT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (rd_idx),
    .wr_data   (wr_data),
    .rd_a_idx  (rs_idx),
    .rd_b_idx  (rt_idx),
    .spec_vals (spec_vals),
    .rd_a      (rs_val),
    .rd_b      (rt_val)
  );

  lane_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op        (op_sel),
    .opa       (rs_val),
    .opb       (rt_val),
    .result    (alu_out),
    .cmp_flags (cmp_flags)
  );

  lane_flow #(
    .ADDR_W (ADDR_W)
  ) u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .op        (op_sel),
    .cmp_flags (cmp_flags),
    .cond_mask (cond_mask),
    .target    (br_target),
    .nzp_q     (nzp_q),
    .pc_q      (pc),
    .br_taken  (br_taken)
  );

  assign nzp = nzp_q;

endmodule

// File: rtl/thread_lane_chk.sv
module thread_lane_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int REG_CNT  = 16,
  parameter int SPEC_CNT = 3,
  localparam int IDX_W   = $clog2(REG_CNT),
  localparam int GEN_CNT = REG_CNT - SPEC_CNT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic [3:0]        op_sel,
  input logic [IDX_W-1:0]  rs_idx,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] blk_idx,
  input logic [ADDR_W-1:0] br_target,
  input logic [2:0]        nzp,
  input logic [ADDR_W-1:0] pc,
  input logic              br_taken
);
  import lane_pkg::*;

  // R7
  nzp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nzp) <= 1);

  // R7
  cmp_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op_sel == OP_CMP) |=> $countones(nzp) == 1);

  // R10
  nzp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && op_sel == OP_CMP) |=> $stable(nzp));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(pc));

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !br_taken) |=> pc == ADDR_W'($past(pc) + 1'b1));

  // R8
  pc_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && br_taken) |=> pc == $past(br_target));

  // R2
  spec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == IDX_W'(GEN_CNT)) |-> rs_val == blk_idx);

endmodule

bind thread_lane thread_lane_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .REG_CNT  (REG_CNT),
  .SPEC_CNT (SPEC_CNT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .commit    (commit),
  .op_sel    (op_sel),
  .rs_idx    (rs_idx),
  .rs_val    (rs_val),
  .blk_idx   (blk_idx),
  .br_target (br_target),
  .nzp       (nzp),
  .pc        (pc),
  .br_taken  (br_taken)
);

// File: tb/test_thread_lane.sv
module test_thread_lane;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       commit = 1'b0;
  logic [3:0] op_sel = '0;
  logic [3:0] rd_idx = '0, rs_idx = '0, rt_idx = '0;
  logic [7:0] imm_val = '0, br_target = '0;
  logic [2:0] cond_mask = '0;
  logic [7:0] blk_idx = 8'h5A, blk_dim = 8'h20, thr_idx = 8'h07;
  logic [7:0] rs_val, rt_val, alu_out, pc;
  logic [2:0] nzp;

  int checks = 0;
  int errors = 0;

  int mreg [13];
  int mnzp = 0;
  int mpc  = 0;

  localparam logic [7:0] VALS [13] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd15, 8'd16,
                                      8'd100, 8'd127, 8'd128, 8'd200, 8'd254, 8'd255};

  thread_lane i_thread_lane (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op_sel(op_sel),
    .rd_idx(rd_idx), .rs_idx(rs_idx), .rt_idx(rt_idx), .imm_val(imm_val),
    .br_target(br_target), .cond_mask(cond_mask), .blk_idx(blk_idx),
    .blk_dim(blk_dim), .thr_idx(thr_idx), .rs_val(rs_val), .rt_val(rt_val),
    .alu_out(alu_out), .nzp(nzp), .pc(pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mread(input int idx);
    if (idx == 13) return int'(blk_idx);
    if (idx == 14) return int'(blk_dim);
    if (idx == 15) return int'(thr_idx);
    return mreg[idx];
  endfunction

  // arithmetic restated independently of the design
  function automatic int mcalc(input int op, input int a, input int b);
    case (op)
      3: return (a + b) % 256;
      4: return (a - b + 256) % 256;
      5: return (a * b) % 256;
      6: return (b == 0) ? 0 : a / b;
      default: return 0;
    endcase
  endfunction

  task automatic peek(input int idx, output logic [7:0] v);
    @(negedge clk);
    rs_idx = 4'(idx);
    #1 v = rs_val;
  endtask

  // drive one instruction with commit, update the model, check pc and flags
  task automatic issue(input int op, input int rd, input int rs, input int rt,
                       input int im, input int tgt, input int mask);
    int a, b;
    a = mread(rs);
    b = mread(rt);
    @(negedge clk);
    op_sel = 4'(op); rd_idx = 4'(rd); rs_idx = 4'(rs); rt_idx = 4'(rt);
    imm_val = 8'(im); br_target = 8'(tgt); cond_mask = 3'(mask);
    commit = 1'b1;
    if (op == 1 && (mnzp & mask) != 0) mpc = tgt;
    else mpc = (mpc + 1) % 256;
    if (op == 2) mnzp = (a < b) ? 4 : (a == b) ? 2 : 1;
    if (rd < 13) begin
      if (op >= 3 && op <= 6) mreg[rd] = mcalc(op, a, b);
      else if (op == 7) mreg[rd] = im;
    end
    @(posedge clk);
    #1 commit = 1'b0;
    chk("R8", "pc after commit", 32'(pc), 32'(mpc));
    chk("R10", "flags after commit", 32'(nzp), 32'(mnzp));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++; checks++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int k = 0; k < 13; k++) mreg[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1", "pc at reset", 32'(pc), 0);
    chk("R1", "flags at reset", 32'(nzp), 0);
    for (int k = 0; k < 13; k++) begin
      peek(k, v);
      chk("R1", $sformatf("reg %0d at reset", k), 32'(v), 0);
    end

    // R2 identity registers on both ports
    for (int k = 13; k < 16; k++) begin
      @(negedge clk);
      rs_idx = 4'(k); rt_idx = 4'(k);
      #1;
      chk("R2", $sformatf("rs port reg %0d", k), 32'(rs_val), 32'(mread(k)));
      chk("R2", $sformatf("rt port reg %0d", k), 32'(rt_val), 32'(mread(k)));
    end

    // R6 load immediates into every general register
    for (int k = 0; k < 13; k++) issue(7, k, 0, 0, int'(VALS[k]), 0, 0);
    for (int k = 0; k < 13; k++) begin
      peek(k, v);
      chk("R6", $sformatf("reg %0d after const", k), 32'(v), 32'(mreg[k]));
    end

    // R3 writes aimed at identity registers are dropped
    issue(7, 13, 0, 0, 8'hEE, 0, 0);
    issue(7, 14, 0, 0, 8'hEE, 0, 0);
    issue(3, 15, 11, 12, 0, 0, 0);
    blk_idx = 8'h33; blk_dim = 8'h40; thr_idx = 8'h1F;
    for (int k = 13; k < 16; k++) begin
      peek(k, v);
      chk("R3", $sformatf("reg %0d after write attempt", k), 32'(v), 32'(mread(k)));
    end

    // R4 R5 operand sweep on alu_out, no commit
    for (int op = 3; op <= 6; op++) begin
      for (int i = 0; i < 13; i++) begin
        for (int j = 0; j < 13; j++) begin
          @(negedge clk);
          op_sel = 4'(op); rs_idx = 4'(i); rt_idx = 4'(j);
          #1;
          chk((op == 6) ? "R5" : "R4", $sformatf("op %0d a=%0d b=%0d", op, mreg[i], mreg[j]),
              32'(alu_out), 32'(mcalc(op, mreg[i], mreg[j])));
        end
      end
    end

    // R9 the sweep had no commit: state held
    chk("R9", "pc held without commit", 32'(pc), 32'(mpc));
    chk("R9", "flags held without commit", 32'(nzp), 32'(mnzp));
    @(negedge clk);
    op_sel = 4'd7; rd_idx = 4'd0; imm_val = 8'h99; commit = 1'b0;
    @(posedge clk);
    peek(0, v);
    chk("R9", "reg 0 held without commit", 32'(v), 32'(mreg[0]));

    // R4 R5 committed writes, including divide by zero and wrap
    issue(3, 12, 11, 10, 0, 0, 0);
    peek(12, v);
    chk("R4", "add wrap written", 32'(v), 32'(mreg[12]));
    issue(4, 12, 1, 11, 0, 0, 0);
    peek(12, v);
    chk("R4", "sub wrap written", 32'(v), 32'(mreg[12]));
    issue(5, 12, 11, 11, 0, 0, 0);
    peek(12, v);
    chk("R4", "mul wrap written", 32'(v), 32'(mreg[12]));
    issue(6, 12, 10, 0, 0, 0, 0);
    peek(12, v);
    chk("R5", "divide by zero written", 32'(v), 0);
    issue(6, 12, 10, 4, 0, 0, 0);
    peek(12, v);
    chk("R5", "divide written", 32'(v), 32'(200 / 7));

    // R7 compare every pair; R10 compare writes no register
    for (int i = 0; i < 13; i++) begin
      for (int j = 0; j < 13; j++) begin
        issue(2, 0, i, j, 0, 0, 0);
        chk("R7", $sformatf("cmp %0d vs %0d", mreg[i], mreg[j]), 32'(nzp),
            (mreg[i] < mreg[j]) ? 4 : (mreg[i] == mreg[j]) ? 2 : 1);
      end
    end
    peek(0, v);
    chk("R10", "reg 0 untouched by compares", 32'(v), 32'(mreg[0]));

    // R8 every flag state against every mask
    for (int f = 0; f < 3; f++) begin
      for (int m = 0; m < 8; m++) begin
        issue(2, 0, (f == 2) ? 2 : 1, (f == 0) ? 2 : 1, 0, 0, 0);
        issue(1, 0, 0, 0, 0, 16 + 8 * f + m, m);
      end
    end

    // R8 wrap 255 -> 0
    issue(1, 0, 0, 0, 0, 255, 7);
    chk("R8", "branch to 255", 32'(pc), 255);
    issue(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "pc wraps", 32'(pc), 0);

    // R10 opcodes 8..15 act as no-ops
    for (int op = 8; op < 16; op++) issue(op, 1, 11, 11, 8'h55, 9, 7);
    peek(1, v);
    chk("R10", "reg 1 untouched by spare opcodes", 32'(v), 32'(mreg[1]));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule